// File: doc/BRIEF.md
# Multipurpose Output Pin Selector

This block drives one general-purpose output pin that serves a pair of serial channels. A 3-bit routing code picks what appears on the pin. The choices are a request-to-send line, the counter/timer output, four bit-rate clocks (the transmit and receive clocks at 1X and 16X), and two status flags. The CPU loads the code with a one-cycle write strobe. The clock generators, the counter and the serial datapath sit outside the block and supply their signals as inputs.

The request-to-send line is the only stateful source. A flag inside the block holds it, and CPU commands set and clear that flag. The pin is active low: it reads 0 while the flag is asserted. Two enables let the flag negate itself without a CPU command. One fires when the transmitter has finished shifting its last character out. The other fires when the receive FIFO and the receive shift register are both full.

A separate mode input turns two companion pins into outputs carrying the transmit-ready and receive-ready/FIFO-full flags. When the mode input is low, those pins are left as inputs.

Top module: `mpo_pin_sel`

## Requirements
- R1: After reset the routing code is 000 and the request-to-send flag is negated, so `mpo` reads 1.
- R2: When `sel_we` is high at a clock edge, `sel_wdata` becomes the routing code from the next cycle onward. Without `sel_we` the code holds its value.
- R3: With code 000, `mpo` is the inverse of the request-to-send flag: 0 while asserted, 1 while negated.
- R4: `rts_set` at a clock edge asserts the flag, and it stays asserted while no clear condition is present.
- R5: `rts_clr` at a clock edge, without `rts_set`, negates the flag.
- R6: While `auto_tx_en` is 1, a high `tx_shift_done` at an edge negates the flag. While `auto_tx_en` is 0, `tx_shift_done` has no effect on it.
- R7: While `auto_rx_en` is 1, a high `rx_full` at an edge negates the flag. While `auto_rx_en` is 0, `rx_full` has no effect on it.
- R8: `rts_set` wins over `rts_clr` and over both automatic negations when they occur in the same cycle.
- R9: The other codes route inputs to `mpo` combinationally: 001 `ctr_out`, 010 `tx_clk_1x`, 011 `tx_clk_16x`, 100 `rx_clk_1x`, 101 `rx_clk_16x`, 110 `tx_rdy`, 111 `rx_rdy_ffull`.
- R10: `mpp_oe` follows `mpp_out_mode`. While the mode is 1, `mpp_tx_rdy` follows `tx_rdy` and `mpp_rx_rdy` follows `rx_rdy_ffull`. While the mode is 0, both read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_we | input | 1 | Write strobe for the routing code |
| sel_wdata | input | 3 | New routing code |
| rts_set | input | 1 | Command: assert request-to-send |
| rts_clr | input | 1 | Command: negate request-to-send |
| auto_tx_en | input | 1 | Enables negation once the transmitter is empty |
| auto_rx_en | input | 1 | Enables negation when the receiver is full |
| tx_shift_done | input | 1 | Transmitter has shifted its last character out |
| rx_full | input | 1 | Receive FIFO and receive shift register both full |
| ctr_out | input | 1 | Counter/timer output |
| tx_clk_1x | input | 1 | Transmit 1X shift clock |
| tx_clk_16x | input | 1 | Transmit 16X clock |
| rx_clk_1x | input | 1 | Receive 1X sampling clock |
| rx_clk_16x | input | 1 | Receive 16X clock |
| tx_rdy | input | 1 | Transmitter-ready flag |
| rx_rdy_ffull | input | 1 | Receiver-ready or FIFO-full flag |
| mpp_out_mode | input | 1 | Makes the companion pins outputs |
| mpo | output | 1 | Multipurpose output pin |
| mpp_oe | output | 1 | Output enable for the companion pins |
| mpp_tx_rdy | output | 1 | Companion pin carrying transmit-ready |
| mpp_rx_rdy | output | 1 | Companion pin carrying receive-ready/full |

## Verification
Random cycles draw all eight routing codes, with every source input toggling on its own. A source routed to the wrong code therefore shows up as a mismatch, even when two sources happen to agree for a while.

Directed sequences drive the flag one condition at a time: set, clear, each automatic negation with its enable on and then off, and all conditions together. This separates a wrong priority from an enable that is ignored or a pair of enables that are swapped.

A code write is checked both in its own cycle and in the cycle after. That shows the code is registered and not passed straight through.

// File: rtl/mpo_pin_sel.sv
module mpo_pin_sel (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sel_we,
  input  logic [2:0] sel_wdata,
  input  logic       rts_set,
  input  logic       rts_clr,
  input  logic       auto_tx_en,
  input  logic       auto_rx_en,
  input  logic       tx_shift_done,
  input  logic       rx_full,
  input  logic       ctr_out,
  input  logic       tx_clk_1x,
  input  logic       tx_clk_16x,
  input  logic       rx_clk_1x,
  input  logic       rx_clk_16x,
  input  logic       tx_rdy,
  input  logic       rx_rdy_ffull,
  input  logic       mpp_out_mode,
  output logic       mpo,
  output logic       mpp_oe,
  output logic       mpp_tx_rdy,
  output logic       mpp_rx_rdy
);

  localparam logic [2:0] SEL_RTS = 3'd0;
  localparam logic [2:0] SEL_CTR = 3'd1;
  localparam logic [2:0] SEL_TX1 = 3'd2;
  localparam logic [2:0] SEL_TX16 = 3'd3;
  localparam logic [2:0] SEL_RX1 = 3'd4;
  localparam logic [2:0] SEL_RX16 = 3'd5;
  localparam logic [2:0] SEL_TXR = 3'd6;

  logic [2:0] sel_q;
  logic       rts_q;
  logic       auto_neg;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      sel_q <= SEL_RTS;
    else if (sel_we) sel_q <= sel_wdata;

  assign auto_neg = (auto_tx_en & tx_shift_done) | (auto_rx_en & rx_full);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                   rts_q <= 1'b0;
    else if (rts_set)             rts_q <= 1'b1;
    else if (rts_clr || auto_neg) rts_q <= 1'b0;

  always_comb
    case (sel_q)
      SEL_RTS:  mpo = ~rts_q;
      SEL_CTR:  mpo = ctr_out;
      SEL_TX1:  mpo = tx_clk_1x;
      SEL_TX16: mpo = tx_clk_16x;
      SEL_RX1:  mpo = rx_clk_1x;
      SEL_RX16: mpo = rx_clk_16x;
      SEL_TXR:  mpo = tx_rdy;
      default:  mpo = rx_rdy_ffull;
    endcase

  assign mpp_oe     = mpp_out_mode;
  assign mpp_tx_rdy = mpp_out_mode & tx_rdy;
  assign mpp_rx_rdy = mpp_out_mode & rx_rdy_ffull;

  // R2
  sel_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_we |=> sel_q == $past(sel_wdata));
  // R2
  sel_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_we |=> $stable(sel_q));
  // R4 R8
  rts_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rts_set |=> rts_q);
  // R5
  rts_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_clr && !rts_set) |=> !rts_q);
  // R6
  auto_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_tx_en && tx_shift_done && !rts_set) |=> !rts_q);
  // R7
  auto_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (auto_rx_en && rx_full && !rts_set) |=> !rts_q);
  // R4 R6 R7
  rts_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rts_set && !rts_clr && !(auto_tx_en && tx_shift_done) && !(auto_rx_en && rx_full))
      |=> $stable(rts_q));

endmodule

// File: tb/mpo_pin_sel_tb_top.sv
module mpo_pin_sel_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel_we = 0, rts_set = 0, rts_clr = 0, auto_tx_en = 0, auto_rx_en = 0;
  logic tx_shift_done = 0, rx_full = 0, ctr_out = 0, tx_clk_1x = 0, tx_clk_16x = 0;
  logic rx_clk_1x = 0, rx_clk_16x = 0, tx_rdy = 0, rx_rdy_ffull = 0, mpp_out_mode = 0;
  logic [2:0] sel_wdata = 3'd0;
  logic mpo, mpp_oe, mpp_tx_rdy, mpp_rx_rdy;

  int total = 0;
  int bad = 0;
  logic [2:0] sel_m = 3'd0;
  logic rts_m = 1'b0;

  always #5 clk = ~clk;

  mpo_pin_sel dut_i (.*);

  function automatic logic exp_mpo(logic [2:0] s);
    case (s)
      3'd0: return ~rts_m;
      3'd1: return ctr_out;
      3'd2: return tx_clk_1x;
      3'd3: return tx_clk_16x;
      3'd4: return rx_clk_1x;
      3'd5: return rx_clk_16x;
      3'd6: return tx_rdy;
      default: return rx_rdy_ffull;
    endcase
  endfunction

  function automatic logic next_rts(logic cur);
    if (rts_set) return 1'b1;
    if (rts_clr || (auto_tx_en && tx_shift_done) || (auto_rx_en && rx_full)) return 1'b0;
    return cur;
  endfunction

  task automatic chk(string tag, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: got %b expected %b (sel=%0d t=%0t)", tag, act, exp, sel_m, $time);
    end
  endtask

  task automatic step(string tag);
    #2;
    chk(tag, mpo, exp_mpo(sel_m));
    chk("R10", mpp_oe, mpp_out_mode);
    chk("R10", mpp_tx_rdy, mpp_out_mode & tx_rdy);
    chk("R10", mpp_rx_rdy, mpp_out_mode & rx_rdy_ffull);
    @(posedge clk);
    rts_m = next_rts(rts_m);
    if (sel_we) sel_m = sel_wdata;
    @(negedge clk);
  endtask

  task automatic idle();
    sel_we = 0; rts_set = 0; rts_clr = 0; auto_tx_en = 0; auto_rx_en = 0;
    tx_shift_done = 0; rx_full = 0;
  endtask

  initial begin
    #2000000;
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #1;
    chk("R1", mpo, 1'b1);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    step("R1");
    rts_set = 1; step("R4");
    idle(); step("R4");
    chk("R4", rts_m, 1'b1);
    step("R3");
    rts_clr = 1; step("R5");
    idle(); step("R5");
    rts_set = 1; step("R4");
    idle(); tx_shift_done = 1; step("R6");
    step("R6");
    auto_tx_en = 1; step("R6");
    idle(); step("R6");
    rts_set = 1; step("R4");
    idle(); rx_full = 1; step("R7");
    auto_tx_en = 1; step("R7");
    auto_tx_en = 0; auto_rx_en = 1; step("R7");
    idle(); step("R7");
    rts_set = 1; rts_clr = 1; auto_tx_en = 1; tx_shift_done = 1;
    auto_rx_en = 1; rx_full = 1; step("R8");
    idle(); step("R8");
    sel_we = 1; sel_wdata = 3'd6; tx_rdy = 1; step("R2");
    sel_we = 0; step("R2");
    sel_wdata = 3'd1; step("R2");
    mpp_out_mode = 1; rx_rdy_ffull = 1; step("R10");
    mpp_out_mode = 0; step("R10");
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      sel_we = ($urandom % 4) == 0;
      sel_wdata = 3'($urandom);
      rts_set = ($urandom % 6) == 0;
      rts_clr = ($urandom % 6) == 0;
      auto_tx_en = $urandom; auto_rx_en = $urandom;
      tx_shift_done = $urandom; rx_full = ($urandom % 3) == 0;
      ctr_out = $urandom; tx_clk_1x = $urandom; tx_clk_16x = $urandom;
      rx_clk_1x = $urandom; rx_clk_16x = $urandom; tx_rdy = $urandom;
      rx_rdy_ffull = $urandom; mpp_out_mode = $urandom;
      step(sel_m == 3'd0 ? "R3" : "R9");
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule